// File: doc/BRIEF.md
# Chained Serial Converter Frame Writer

This block is the host-side engine that programs a string of serial-input converters wired in a chain. All converters share one serial clock and one select/load line, and each one's shift-register output drives the next one's data input. A pulse on `start_i` captures one 16-bit code per converter from a flat code bus. The block then drops select/load and clocks the whole chain's worth of bits out in one frame. A single rising edge on select/load ends the frame, and every converter takes up its new code on that same edge.

The bit stream begins with the code for the converter farthest from the controller, so once the last bit has entered the chain, each code sits in its own device. Each minimum interface time is given as a parameter in picoseconds. A package function rounds it up to whole system-clock cycles, so a slower or faster system clock only needs a new clock-period parameter. `busy_o` covers the transfer and `done_o` marks its end.

Top module: `dcw_chain_writer`

## Requirements
- R1: Out of reset, select/load is high, the serial clock is low, and busy and done are both low.
- R2: During one frame, the serial clock rises exactly NUM_DEV×CODE_W times while select/load is low. Select/load then rises exactly once.
- R3: The bit present at each serial-clock rise follows `codes_i` from bit NUM_DEV×CODE_W−1 down to bit 0. The slice in the top CODE_W bits belongs to the farthest converter and goes first, most significant bit first.
- R4: The data line never changes while the serial clock is high or in the cycle where it rises. While select/load is low, the data line changes only in the cycle where the serial clock falls.
- R5: Each serial-clock high phase lasts at least the clock-high minimum (8 cycles by default). Each low phase between two rises lasts at least the larger of the clock-low minimum and the data setup minimum (8 cycles by default).
- R6: The first serial-clock rise comes at least the larger of the select-to-clock minimum and the setup minimum after select/load falls (8 cycles by default).
- R7: Select/load rises at least the last-clock-to-load minimum after the last serial-clock rise (8 cycles by default).
- R8: The serial clock is low whenever select/load is high. Between frames, select/load stays high at least the larger of the load-pulse minimum and the clock-low-before-select minimum (10 cycles by default).
- R9: busy is high from the cycle after an accepted start until the cycle in which select/load rises. In that cycle done is high, and done stays high for that one cycle only.
- R10: Codes are captured only when a start arrives while not busy. A start pulse or a change on `codes_i` during a frame alters neither that frame nor the frames that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, one cycle |
| codes_i | input | NUM_DEV*CODE_W | Codes, farthest converter in the top slice |
| sclk_o | output | 1 | Shared serial clock |
| sdata_o | output | 1 | Serial data into the first converter |
| sel_ld_o | output | 1 | Shared select (low) / load (rising edge) |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The frames use codes chosen to expose specific faults. Codes such as 0x8000/0x7FFF/0x0001 in different slices catch reversed device order and reversed bit order. Alternating patterns catch a data line sampled one bit early or late. All-zero and all-one frames check that the bit count is right even when the data never toggles. Back-to-back frames started in the cycle after done test the minimum high time of select/load. A mid-frame start together with a changed code bus must leave the wire image and the frame count unchanged. Every phase length is measured on the pins against its minimum.

// File: rtl/dcw_pkg.sv
`timescale 1ns/1ps
package dcw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_TAIL
  } dcw_state_e;

  // minimum time in ps -> whole clock cycles, rounded up, never below one
  function automatic int unsigned ps_to_cyc(input int unsigned t_ps,
                                            input int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // cycles still needed after the high phase so the rise-to-load gap holds
  function automatic int unsigned tail_cyc(input int unsigned rise_to_load,
                                           input int unsigned hi_cyc);
    return (rise_to_load > hi_cyc) ? (rise_to_load - hi_cyc) : 1;
  endfunction

endpackage

// File: rtl/dcw_phase_timer.sv
`timescale 1ns/1ps
module dcw_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] value_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= value_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // a new phase never cuts the running one short
  AST_LOAD_ONLY_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> expired_o); // R5

endmodule

// File: rtl/dcw_frame_shifter.sv
`timescale 1ns/1ps
module dcw_frame_shifter #(
  parameter int FW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture_i,
  input  logic [FW-1:0] frame_i,
  input  logic          rise_i,
  input  logic          advance_i,
  output logic          sdata_o,
  output logic          last_o
);

  localparam int BW = $clog2(FW + 1);

  logic [FW-1:0] sreg_q;
  logic [BW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      left_q <= '0;
    end else begin
      if (capture_i) begin
        sreg_q <= frame_i;
        left_q <= BW'(FW);
      end else begin
        if (advance_i) sreg_q <= {sreg_q[FW-2:0], 1'b0};
        if (rise_i)    left_q <= left_q - 1'b1;
      end
    end
  end

  assign sdata_o = sreg_q[FW-1];
  assign last_o  = (left_q == '0);

  AST_NO_EXTRA_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_i |-> !last_o); // R2

  AST_CAPTURE_BETWEEN_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i |-> last_o); // R10

endmodule

// File: rtl/dcw_gap_meter.sv
`timescale 1ns/1ps
module dcw_gap_meter #(
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  output logic ready_o
);

  localparam int GW = $clog2(LIMIT + 1);

  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (!sel_i)             cnt_q <= '0;
    else if (cnt_q < GW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  // leaving ARM at this count makes the high time exactly LIMIT cycles
  assign ready_o = (cnt_q >= GW'(LIMIT - 1));

endmodule

// File: rtl/dcw_chain_writer.sv
`timescale 1ns/1ps
module dcw_chain_writer
  import dcw_pkg::*;
#(
  parameter int NUM_DEV     = 3,
  parameter int CODE_W      = 16,
  parameter int CLK_PS      = 5000,
  parameter int SETUP_PS    = 40000,
  parameter int CK_HI_PS    = 40000,
  parameter int CK_LO_PS    = 40000,
  parameter int CK_SEL_PS   = 20000,
  parameter int SEL_CK_PS   = 20000,
  parameter int CK_LOAD_PS  = 40000,
  parameter int LOAD_HI_PS  = 50000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [NUM_DEV*CODE_W-1:0] codes_i,
  output logic                      sclk_o,
  output logic                      sdata_o,
  output logic                      sel_ld_o,
  output logic                      busy_o,
  output logic                      done_o
);

  localparam int FW      = NUM_DEV * CODE_W;
  localparam int SU_C    = ps_to_cyc(SETUP_PS, CLK_PS);
  localparam int HI_C    = ps_to_cyc(CK_HI_PS, CLK_PS);
  localparam int LOW_C   = umax(ps_to_cyc(CK_LO_PS, CLK_PS), SU_C);
  localparam int LEAD_C  = umax(ps_to_cyc(SEL_CK_PS, CLK_PS), SU_C);
  localparam int TAIL_C  = tail_cyc(ps_to_cyc(CK_LOAD_PS, CLK_PS), HI_C);
  localparam int ARM_C   = umax(ps_to_cyc(LOAD_HI_PS, CLK_PS), ps_to_cyc(CK_SEL_PS, CLK_PS));
  localparam int TMR_MAX = umax(umax(HI_C, LOW_C), umax(LEAD_C, TAIL_C));
  localparam int TW      = $clog2(TMR_MAX + 1);

  dcw_state_e  st_q;
  logic        sclk_q, sel_q, busy_q, done_q;
  logic        tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic        gap_ready, last_bit;

  // named events between FSM, timer, shifter and gap meter
  logic capture_ev, launch_ev, rise_ev, fall_ev, advance_ev, finish_ev;

  assign capture_ev = (st_q == ST_IDLE) && start_i;
  assign launch_ev  = (st_q == ST_ARM) && gap_ready;
  assign rise_ev    = ((st_q == ST_LEAD) || (st_q == ST_LOW)) && tmr_zero;
  assign fall_ev    = (st_q == ST_HIGH) && tmr_zero;
  assign advance_ev = fall_ev && !last_bit;
  assign finish_ev  = (st_q == ST_TAIL) && tmr_zero;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (launch_ev) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(LEAD_C - 1);
    end else if (rise_ev) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(HI_C - 1);
    end else if (fall_ev) begin
      tmr_load = 1'b1;
      tmr_val  = last_bit ? TW'(TAIL_C - 1) : TW'(LOW_C - 1);
    end
  end

  dcw_phase_timer #(.W(TW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (tmr_load),
    .value_i   (tmr_val),
    .expired_o (tmr_zero)
  );

  dcw_frame_shifter #(.FW(FW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (capture_ev),
    .frame_i   (codes_i),
    .rise_i    (rise_ev),
    .advance_i (advance_ev),
    .sdata_o   (sdata_o),
    .last_o    (last_bit)
  );

  dcw_gap_meter #(.LIMIT(ARM_C)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_i   (sel_q),
    .ready_o (gap_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sclk_q <= 1'b0;
      sel_q  <= 1'b1;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (capture_ev) begin
          st_q   <= ST_ARM;
          busy_q <= 1'b1;
        end
        ST_ARM: if (launch_ev) begin
          st_q  <= ST_LEAD;
          sel_q <= 1'b0;
        end
        ST_LEAD, ST_LOW: if (rise_ev) begin
          st_q   <= ST_HIGH;
          sclk_q <= 1'b1;
        end
        ST_HIGH: if (fall_ev) begin
          sclk_q <= 1'b0;
          st_q   <= last_bit ? ST_TAIL : ST_LOW;
        end
        ST_TAIL: if (finish_ev) begin
          st_q   <= ST_IDLE;
          sel_q  <= 1'b1;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sclk_o   = sclk_q;
  assign sel_ld_o = sel_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  AST_CLK_LOW_WHILE_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q |-> !sclk_q); // R8

  AST_DATA_HELD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> $stable(sdata_o)); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9

  AST_BUSY_COVERS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q |-> busy_q); // R9

  AST_DONE_ON_LOAD_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($rose(sel_q) && !busy_q)); // R9

endmodule

// File: tb/dcw_chain_writer_test.sv
`timescale 1ns/1ps
module dcw_chain_writer_test;

  localparam int NDEV = 3;
  localparam int CW   = 16;
  localparam int FW   = NDEV * CW;
  localparam int PER_NS = 5;
  // minimums restated in ns, rounded up to 5 ns cycles
  localparam int MIN_HI   = (40 + PER_NS - 1) / PER_NS;
  localparam int MIN_LO   = (40 + PER_NS - 1) / PER_NS;
  localparam int MIN_LEAD = (40 + PER_NS - 1) / PER_NS; // setup dominates 20 ns
  localparam int MIN_TAIL = (40 + PER_NS - 1) / PER_NS;
  localparam int MIN_GAP  = (50 + PER_NS - 1) / PER_NS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [FW-1:0] codes_i = '0;
  logic sclk_o, sdata_o, sel_ld_o, busy_o, done_o;

  dcw_chain_writer uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .codes_i(codes_i),
    .sclk_o(sclk_o), .sdata_o(sdata_o), .sel_ld_o(sel_ld_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [FW-1:0] expq[$];

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // ---------------- monitor ----------------
  logic p_sel = 1'b1, p_sclk = 1'b0, p_sd = 1'b0, p_done = 1'b0;
  int lead_n = 0, hi_n = 0, lo_n = 0, since_rise = 0, gap_n = 0;
  int nbits = 0;
  bit first_rise = 1'b0, gap_valid = 1'b0;
  logic [FW-1:0] rx = '0;
  int frames_seen = 0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      lead_n++; hi_n++; lo_n++; since_rise++; gap_n++;
      if (sel_ld_o && sclk_o)
        check(1'b0, "R8 clock high while select high", 1, 0);
      if (!sel_ld_o && !busy_o)
        check(1'b0, "R9 busy low during frame", busy_o, 1);
      if (p_sclk && sclk_o && sdata_o !== p_sd)
        check(1'b0, "R4 data moved while clock high", sdata_o, p_sd);
      if (!p_sel && !sel_ld_o && !p_sclk && !sclk_o && sdata_o !== p_sd)
        check(1'b0, "R4 data moved while clock low", sdata_o, p_sd);
      if (p_done)
        check(!done_o, "R9 done wider than one cycle", done_o, 0);
      // select falls
      if (p_sel && !sel_ld_o) begin
        if (gap_valid) check(gap_n >= MIN_GAP, "R8 select high time", gap_n, MIN_GAP);
        lead_n = 0; nbits = 0; first_rise = 1'b1; rx = '0;
      end
      // clock rises
      if (!p_sclk && sclk_o) begin
        check(!sdata_o === !p_sd, "R4 data moved at rise", sdata_o, p_sd);
        if (first_rise) check(lead_n >= MIN_LEAD, "R6 select-to-first-rise", lead_n, MIN_LEAD);
        else check(lo_n >= MIN_LO, "R5 low phase", lo_n, MIN_LO);
        first_rise = 1'b0;
        rx = {rx[FW-2:0], sdata_o};
        nbits++;
        hi_n = 0; since_rise = 0;
      end
      // clock falls
      if (p_sclk && !sclk_o) begin
        check(hi_n >= MIN_HI, "R5 high phase", hi_n, MIN_HI);
        lo_n = 0;
      end
      // select rises: frame complete
      if (!p_sel && sel_ld_o) begin
        frames_seen++;
        check(since_rise >= MIN_TAIL, "R7 last-rise-to-load", since_rise, MIN_TAIL);
        check(nbits == FW, "R2 rise count", nbits, FW);
        check(done_o && !busy_o, "R9 done/busy at load edge", {done_o, busy_o}, 2'b10);
        if (expq.size() == 0) begin
          check(1'b0, "R10 unexpected frame", rx, 0);
        end else begin
          logic [FW-1:0] e;
          e = expq.pop_front();
          check(rx == e, "R3 frame bits", rx, e);
        end
        gap_n = 0; gap_valid = 1'b1;
      end else if (done_o) begin
        check(1'b0, "R9 done without load edge", done_o, 0);
      end
      p_sel = sel_ld_o; p_sclk = sclk_o; p_sd = sdata_o; p_done = done_o;
    end
  end

  // ---------------- driver ----------------
  task automatic send(input logic [FW-1:0] c);
    @(negedge clk);
    codes_i = c;
    start_i = 1'b1;
    expq.push_back(c);
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o, "R9 busy after start", busy_o, 1);
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sel_ld_o && !sclk_o && !busy_o && !done_o, "R1 reset state",
          {sel_ld_o, sclk_o, busy_o, done_o}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(sel_ld_o && !sclk_o && !busy_o && !done_o, "R1 after release",
          {sel_ld_o, sclk_o, busy_o, done_o}, 4'b1000);

    // R3 order: farthest slice first, MSB first
    send({16'h8000, 16'h7FFF, 16'h0001});
    wait_done();
    // R10 mid-frame start and code change are ignored
    send({16'hA5A5, 16'h5A5A, 16'hF00F});
    repeat (200) @(negedge clk);
    codes_i = {16'h1234, 16'h5678, 16'h9ABC};
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    repeat (60) @(negedge clk);
    check(sel_ld_o && !busy_o, "R10 no frame from ignored start",
          {sel_ld_o, busy_o}, 2'b10);
    check(frames_seen == 2, "R10 frame count", frames_seen, 2);
    // R2 patterns with no toggles
    send('0);
    wait_done();
    send('1);
    wait_done();
    // back-to-back: start in the cycle right after done (R8 gap)
    send({16'h0F0F, 16'hC3C3, 16'h0180});
    wait_done();
    send({16'hFFFE, 16'h0000, 16'h8001});
    wait_done();
    repeat (40) @(negedge clk);
    check(expq.size() == 0, "R2 all frames delivered", expq.size(), 0);
    check(frames_seen == 6, "R2 frame total", frames_seen, 6);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", 0, 1);
      summary();
    end
  end

endmodule